// File: doc/BRIEF.md
# Page Write Buffer and Program Controller

This block sits between a two-wire serial bus engine and a byte-wide memory array. The engine opens a write transfer with a start command that carries a base address. The low bits of that address select a starting offset inside a 16-byte page, and the upper bits select the page. Each data byte that arrives is stored in a local page buffer at the current offset. The offset then advances and wraps inside the page. A per-offset valid mask records which slots hold data.

Nothing is written to the array while the transfer is open. When the engine signals a stop after at least one data byte, and write protect is low, the block starts a self-timed program cycle. It drains the valid slots into the array, one per clock, in ascending offset order. It holds `busy` high for a fixed number of system clocks, and it ignores all bus commands during that time. At the end of the cycle, the current-address pointer is left one past the last byte written, wrapped inside the page. A stop with no data, a stop under write protect, or a fresh start before any stop discards the buffer and programs nothing.

Top module: `pgw_ctrl`

## Requirements
- R1: After reset `busy` and `mem_we` are 0 and `cur_addr` is 0.
- R2: Data bytes are stored at offsets that begin at the low 4 bits of the start address and go up by one per byte, modulo 16. The page bits (address bits above bit 3) stay fixed, and each byte reaches the array at {page bits, offset}.
- R3: A 17th or later byte wraps to the offset already used and replaces the buffered byte there. Only the newest value is programmed.
- R4: `mem_we` is never asserted before the stop; it is asserted only while `busy` is high.
- R5: A stop that follows at least one byte, with `wp` low, raises `busy` from the cycle after the stop for exactly PROG_CYCLES cycles. A single-byte transfer uses the same cycle.
- R6: A stop with no buffered byte starts no cycle and writes nothing.
- R7: With `wp` high at the stop, no cycle starts, nothing is written and the buffer is discarded. A later transfer programs only its own bytes.
- R8: During a cycle, only the offsets that were written are programmed. There is one write per clock, in ascending offset order, within the first 16 busy cycles.
- R9: A start command issued while a transfer is open discards the bytes buffered so far.
- R10: While `busy` is high, start, byte and stop inputs are ignored.
- R11: When a cycle ends, `cur_addr` becomes {page bits, last offset + 1 mod 16}. It does not change otherwise.
- R12: A byte strobe in the same cycle as the stop is included in the programmed page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| page_start | input | 1 | Opens a write transfer at `page_addr` |
| page_addr | input | ADDR_W | Base address of the transfer |
| byte_stb | input | 1 | A data byte is present on `byte_data` |
| byte_data | input | 8 | Write data byte |
| stop_stb | input | 1 | Stop seen on the bus |
| wp | input | 1 | Write protect, sampled at the stop |
| mem_we | output | 1 | Array write enable |
| mem_addr | output | ADDR_W | Array write address |
| mem_wdata | output | 8 | Array write data |
| busy | output | 1 | Program cycle in progress |
| cur_addr | output | ADDR_W | Current-address pointer after the last cycle |

## Verification
A data-byte strobe and a stop strobe can arrive in the same clock. Either the engine closes the transfer on the very edge where it hands over the last byte, or it sends a stop with no data at all. The bench provokes this by raising both strobes together after one ordinary byte. It then requires two array writes, with the second byte's value at the next offset, and the pointer one past that. A second collision, a start or stop arriving while the program cycle runs, is judged by the absence of any second busy period and any extra write.

// File: rtl/pgw_pkg.sv
package pgw_pkg;
   typedef enum logic [1:0] {
      PG_IDLE = 2'd0,
      PG_FILL = 2'd1,
      PG_PROG = 2'd2
   } pg_state_t;
endpackage

// File: rtl/pgw_slot_buf.sv
module pgw_slot_buf #(
   parameter int SLOTS  = 16,
   parameter int DATA_W = 8,
   localparam int OFF_W = $clog2(SLOTS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              wr_en,
   input  logic [OFF_W-1:0]  wr_off,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [OFF_W-1:0]  rd_off,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_valid,
   output logic              any_valid
);
   logic [DATA_W-1:0] slot_q [SLOTS];
   logic [SLOTS-1:0]  mask_q;

   for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            mask_q[s] <= 1'b0;
            slot_q[s] <= '0;
         end else if (clr) begin
            mask_q[s] <= 1'b0;
         end else if (wr_en && (wr_off == OFF_W'(s))) begin
            mask_q[s] <= 1'b1;
            slot_q[s] <= wr_data;
         end
      end
   end

   assign rd_data   = slot_q[rd_off];
   assign rd_valid  = mask_q[rd_off];
   assign any_valid = |mask_q;
endmodule

// File: rtl/pgw_prog_timer.sv
module pgw_prog_timer #(
   parameter int CYCLES = 500000,
   localparam int CW    = $clog2(CYCLES + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   output logic running,
   output logic expire
);
   logic [CW-1:0] cnt_q;
   logic          run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         run_q <= 1'b0;
      end else if (load) begin
         cnt_q <= CW'(CYCLES - 1);
         run_q <= 1'b1;
      end else if (run_q) begin
         if (cnt_q == '0) run_q <= 1'b0;
         else             cnt_q <= cnt_q - 1'b1;
      end
   end

   assign running = run_q;
   assign expire  = run_q && (cnt_q == '0);
endmodule

// File: rtl/pgw_ctrl.sv
module pgw_ctrl
   import pgw_pkg::*;
#(
   parameter int ADDR_W      = 11,
   parameter int PAGE_BYTES  = 16,
   parameter int PROG_CYCLES = 500000,
   localparam int OFF_W      = $clog2(PAGE_BYTES),
   localparam int HI_W       = ADDR_W - OFF_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              page_start,
   input  logic [ADDR_W-1:0] page_addr,
   input  logic              byte_stb,
   input  logic [7:0]        byte_data,
   input  logic              stop_stb,
   input  logic              wp,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [7:0]        mem_wdata,
   output logic              busy,
   output logic [ADDR_W-1:0] cur_addr
);
   if ((1 << OFF_W) != PAGE_BYTES) begin : g_bad_page
      $error("PAGE_BYTES must be a power of two");
   end
   if (PROG_CYCLES < PAGE_BYTES) begin : g_bad_time
      $error("PROG_CYCLES must cover one write per page slot");
   end
   if (ADDR_W <= OFF_W) begin : g_bad_addr
      $error("ADDR_W must exceed the page offset width");
   end

   pg_state_t        state_q;
   logic [HI_W-1:0]  page_q;
   logic [OFF_W-1:0] ptr_q;
   logic [OFF_W:0]   drain_q;
   logic [ADDR_W-1:0] cur_q;

   logic buf_clr, buf_wr, any_valid, rd_valid, tmr_run, tmr_expire;
   logic go_prog, fill_stop, drain_live;
   logic [7:0] rd_data;

   assign fill_stop  = (state_q == PG_FILL) && stop_stb && !page_start;
   assign buf_wr     = (state_q == PG_FILL) && byte_stb && !page_start;
   assign go_prog    = fill_stop && (any_valid || byte_stb) && !wp;
   assign buf_clr    = ((state_q != PG_PROG) && page_start)
                     || (fill_stop && !go_prog)
                     || ((state_q == PG_PROG) && tmr_expire);
   assign drain_live = (state_q == PG_PROG) && !drain_q[OFF_W];

   pgw_slot_buf #(.SLOTS(PAGE_BYTES), .DATA_W(8)) u_buf (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (buf_clr),
      .wr_en     (buf_wr),
      .wr_off    (ptr_q),
      .wr_data   (byte_data),
      .rd_off    (drain_q[OFF_W-1:0]),
      .rd_data   (rd_data),
      .rd_valid  (rd_valid),
      .any_valid (any_valid)
   );

   pgw_prog_timer #(.CYCLES(PROG_CYCLES)) u_tmr (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (go_prog),
      .running (tmr_run),
      .expire  (tmr_expire)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= PG_IDLE;
         page_q  <= '0;
         ptr_q   <= '0;
         drain_q <= '0;
         cur_q   <= '0;
      end else begin
         unique case (state_q)
            PG_IDLE, PG_FILL: begin
               if (page_start) begin
                  page_q  <= page_addr[ADDR_W-1:OFF_W];
                  ptr_q   <= page_addr[OFF_W-1:0];
                  state_q <= PG_FILL;
               end else if (state_q == PG_FILL) begin
                  if (buf_wr) ptr_q <= ptr_q + 1'b1;
                  if (stop_stb) begin
                     state_q <= go_prog ? PG_PROG : PG_IDLE;
                     drain_q <= '0;
                  end
               end
            end
            PG_PROG: begin
               if (drain_live) drain_q <= drain_q + 1'b1;
               if (tmr_expire) begin
                  state_q <= PG_IDLE;
                  cur_q   <= {page_q, ptr_q};
               end
            end
            default: state_q <= PG_IDLE;
         endcase
      end
   end

   assign busy      = (state_q == PG_PROG) && tmr_run;
   assign mem_we    = drain_live && rd_valid;
   assign mem_addr  = {page_q, drain_q[OFF_W-1:0]};
   assign mem_wdata = rd_data;
   assign cur_addr  = cur_q;
endmodule

// File: rtl/pgw_ctrl_chk.sv
module pgw_ctrl_chk #(
   parameter int ADDR_W      = 11,
   parameter int PAGE_BYTES  = 16,
   parameter int PROG_CYCLES = 500000,
   localparam int OFF_W      = $clog2(PAGE_BYTES)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              stop_stb,
   input logic              wp,
   input logic              busy,
   input logic              mem_we,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [ADDR_W-1:0] cur_addr
);
   logic [31:0] bcnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    bcnt <= '0;
      else if (busy) bcnt <= bcnt + 1;
      else           bcnt <= '0;
   end

   p_we_in_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> busy);

   p_busy_length_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (bcnt == 32'(PROG_CYCLES)));

   p_start_by_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(stop_stb));

   p_no_prog_wp_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> !$past(wp));

   p_write_window_r8: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> (bcnt < 32'(PAGE_BYTES)));

   p_page_fixed_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(mem_addr[ADDR_W-1:OFF_W]));

   p_ptr_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(busy) |-> $stable(cur_addr));
endmodule

bind pgw_ctrl pgw_ctrl_chk #(
   .ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES), .PROG_CYCLES(PROG_CYCLES)
) u_chk (
   .clk(clk), .rst_n(rst_n), .stop_stb(stop_stb), .wp(wp), .busy(busy),
   .mem_we(mem_we), .mem_addr(mem_addr), .cur_addr(cur_addr)
);

// File: tb/tb_pgw_ctrl.sv
module tb_pgw_ctrl;
   localparam int AW    = 11;
   localparam int PROG  = 40;
   localparam int DEPTH = 1 << AW;

   logic clk = 1'b0, rst_n = 1'b0;
   logic page_start = 0, byte_stb = 0, stop_stb = 0, wp = 0;
   logic [AW-1:0] page_addr = '0;
   logic [7:0] byte_data = '0;
   logic mem_we, busy;
   logic [AW-1:0] mem_addr, cur_addr;
   logic [7:0] mem_wdata;

   always #10 clk = ~clk;

   pgw_ctrl #(.ADDR_W(AW), .PAGE_BYTES(16), .PROG_CYCLES(PROG)) dut (
      .clk(clk), .rst_n(rst_n), .page_start(page_start), .page_addr(page_addr),
      .byte_stb(byte_stb), .byte_data(byte_data), .stop_stb(stop_stb), .wp(wp),
      .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .busy(busy), .cur_addr(cur_addr));

   logic [7:0] obs_mem [DEPTH];
   logic [7:0] exp_mem [DEPTH];
   int wcount = 0, order_err = 0, prev_off = -1;
   int n_chk = 0, n_fail = 0;
   logic [AW-1:0] exp_cur = '0;
   bit done = 0;

   always @(posedge clk) begin
      if (mem_we) begin
         obs_mem[mem_addr] <= mem_wdata;
         wcount <= wcount + 1;
         if (int'(mem_addr[3:0]) <= prev_off) order_err <= order_err + 1;
         prev_off <= int'(mem_addr[3:0]);
      end
      if (!busy) prev_off <= -1;
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic do_start(input logic [AW-1:0] a);
      page_start = 1; page_addr = a;
      @(negedge clk); page_start = 0;
   endtask

   task automatic do_byte(input logic [7:0] d);
      byte_stb = 1; byte_data = d;
      @(negedge clk); byte_stb = 0;
   endtask

   task automatic do_stop(output int blen);
      stop_stb = 1;
      @(negedge clk); stop_stb = 0;
      blen = 0;
      while (busy) begin blen++; @(negedge clk); end
   endtask

   // vector: {base[10:0], nbytes[4:0], seed[7:0], wp}
   localparam int NV = 7;
   localparam logic [24:0] VEC [NV] = '{
      {11'h123, 5'd1,  8'h5A, 1'b0},   // R5 single byte
      {11'h230, 5'd16, 8'h10, 1'b0},   // R2 full page
      {11'h0FC, 5'd5,  8'h80, 1'b0},   // R2 offset wrap
      {11'h345, 5'd20, 8'h33, 1'b0},   // R3 overwrite
      {11'h400, 5'd3,  8'h77, 1'b1},   // R7 protected
      {11'h500, 5'd0,  8'h00, 1'b0},   // R6 no data
      {11'h7FF, 5'd2,  8'hE0, 1'b0}    // R2 top of array
   };

   initial begin
      for (int i = 0; i < DEPTH; i++) begin obs_mem[i] = 8'h00; exp_mem[i] = 8'h00; end
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(busy == 0, "R1 busy", busy, 0);
      chk(mem_we == 0, "R1 mem_we", mem_we, 0);
      chk(cur_addr == 0, "R1 cur_addr", cur_addr, 0);
      rst_n = 1;
      @(negedge clk);

      for (int v = 0; v < NV; v++) begin
         logic [AW-1:0] base; int n; logic [7:0] seed; logic pw;
         logic [3:0] off; logic [15:0] msk; int w0, blen, ew;
         base = VEC[v][24:14]; n = int'(VEC[v][13:9]); seed = VEC[v][8:1]; pw = VEC[v][0];
         off = base[3:0]; msk = '0;
         w0 = wcount;
         do_start(base);
         for (int i = 0; i < n; i++) begin
            logic [7:0] d;
            d = seed + 8'(i * 13);
            do_byte(d);
            if (!pw) exp_mem[{base[AW-1:4], off}] = d;
            msk[off] = 1'b1;
            off = off + 1'b1;
         end
         chk(wcount == w0, "R4 no write before stop", wcount - w0, 0);
         wp = pw;
         do_stop(blen);
         wp = 0;
         if (n > 0 && !pw) begin
            ew = $countones(msk);
            exp_cur = {base[AW-1:4], off};
            chk(blen == PROG, "R5 busy length", blen, PROG);
         end else begin
            ew = 0;
            chk(blen == 0, pw ? "R7 no cycle" : "R6 no cycle", blen, 0);
         end
         chk(wcount - w0 == ew, "R8 write count", wcount - w0, ew);
         for (int k = 0; k < 16; k++) begin
            logic [AW-1:0] a;
            a = {base[AW-1:4], 4'(k)};
            chk(obs_mem[a] == exp_mem[a], "R3 page data", obs_mem[a], exp_mem[a]);
         end
         chk(cur_addr == exp_cur, "R11 cur_addr", cur_addr, exp_cur);
      end

      // R7 buffer discarded: program one byte into the protected page
      begin
         int w0, blen;
         w0 = wcount;
         do_start(11'h402);
         do_byte(8'hC3); exp_mem[11'h402] = 8'hC3;
         do_stop(blen);
         chk(wcount - w0 == 1, "R7 discard then single", wcount - w0, 1);
         chk(obs_mem[11'h400] == 8'h00, "R7 old byte absent", obs_mem[11'h400], 0);
         exp_cur = 11'h403;
      end

      // R9 restart discards
      begin
         int w0, blen;
         w0 = wcount;
         do_start(11'h600);
         do_byte(8'h11); do_byte(8'h22); do_byte(8'h33);
         do_start(11'h618);
         do_byte(8'h44); exp_mem[11'h618] = 8'h44;
         do_stop(blen);
         chk(wcount - w0 == 1, "R9 restart write count", wcount - w0, 1);
         chk(obs_mem[11'h600] == 8'h00, "R9 discarded byte", obs_mem[11'h600], 0);
         chk(obs_mem[11'h618] == 8'h44, "R9 new byte", obs_mem[11'h618], 8'h44);
         exp_cur = 11'h619;
         chk(cur_addr == exp_cur, "R9 cur_addr", cur_addr, exp_cur);
      end

      // R12 byte and stop in the same cycle
      begin
         int w0, blen;
         w0 = wcount;
         do_start(11'h650);
         do_byte(8'hA1);
         byte_stb = 1; byte_data = 8'hB2;
         do_stop(blen);
         byte_stb = 0;
         chk(wcount - w0 == 2, "R12 write count", wcount - w0, 2);
         chk(obs_mem[11'h651] == 8'hB2, "R12 last byte", obs_mem[11'h651], 8'hB2);
         chk(cur_addr == 11'h652, "R12 cur_addr", cur_addr, 11'h652);
         exp_cur = 11'h652;
      end

      // R10 commands ignored while busy
      begin
         int w0, extra;
         w0 = wcount;
         do_start(11'h700);
         do_byte(8'h5C);
         stop_stb = 1; @(negedge clk); stop_stb = 0;
         repeat (20) @(negedge clk);
         do_start(11'h710);
         do_byte(8'hEE);
         stop_stb = 1; @(negedge clk); stop_stb = 0;
         while (busy) @(negedge clk);
         extra = 0;
         repeat (PROG + 5) begin @(negedge clk); if (busy) extra++; end
         chk(extra == 0, "R10 no second cycle", extra, 0);
         chk(wcount - w0 == 1, "R10 write count", wcount - w0, 1);
         chk(obs_mem[11'h710] == 8'h00, "R10 ignored byte", obs_mem[11'h710], 0);
         chk(cur_addr == 11'h701, "R10 cur_addr", cur_addr, 11'h701);
      end

      chk(order_err == 0, "R8 ascending order", order_err, 0);
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual hung expected done");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule